// File: doc/BRIEF.md
# Soft-Start Reference Sequencer with Open-Load Fault Latch

This block drives the digital reference code that a boost regulator's loop compares its feedback against. While enabled it raises that code from zero toward a target, one code per step period, so the output voltage climbs gently. It also holds a reduced current-limit flag high for a fixed window at the start of each start-up. The target is full scale unless a programmed step is supplied, and a target change while running is approached one code per step period instead of in a jump.

The block watches digital flags from the regulator's comparators: output over-voltage, feedback below half the reference, input undervoltage and over-temperature. Undervoltage and over-temperature gate the switch enable off only while they are present. An open string of LEDs is recognised when over-voltage and low feedback are both seen on a run of consecutive switching-cycle pulses. That condition latches a fault that stops switching and clears the reference until the enable input is taken low.

Top module: `softstart_ref_seq`

## Requirements
- R1: While reset is asserted or `en` is low, `refStep`, `halfLimit`, `switchEn` and `openLoadFault` are all zero; one clock after `en` is sampled low, all four read zero.
- R2: On the clock edge that first samples `en` high the block starts running with `refStep` at 0; from then on `refStep` moves one code toward the target every `STEP_CYCLES` clocks, so code k appears k*`STEP_CYCLES` clocks after that edge.
- R3: The target is `targetStep` when `tgtProgrammed` is 1 and full scale (all ones, 31 for a 5-bit code) when it is 0.
- R4: When the target changes while running, `refStep` moves up or down by at most one code per step period until it equals the new target, and never jumps.
- R5: `halfLimit` is 1 for exactly `HALF_LIM_CYCLES` clocks starting at the edge that starts a run, and 0 afterwards until the next start-up.
- R6: On the `OL_CYCLES`-th consecutive `swCycle` pulse with both `ovFlag` and `fbLowFlag` high, the next edge sets `openLoadFault`, clears `switchEn` and forces `refStep` to 0.
- R7: A `swCycle` pulse on which either `ovFlag` or `fbLowFlag` is low restarts the consecutive count from zero; clocks without a `swCycle` pulse neither add to nor clear the count.
- R8: Once set, `openLoadFault` stays 1, with `switchEn` and `halfLimit` 0 and `refStep` 0, for as long as `en` stays high, whatever the flags do; taking `en` low clears it, and the next enable runs a fresh soft start.
- R9: `uvFlag` high forces `switchEn` to 0 from the next clock; it returns to 1 one clock after the flag clears, and the ramp and timers are unaffected.
- R10: `otFlag` high forces `switchEn` to 0 from the next clock; it returns to 1 one clock after the flag clears, and the ramp and timers are unaffected.
- R11: While running with no fault and neither `uvFlag` nor `otFlag` high, `switchEn` is 1, starting with the edge that starts the run.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| en | input | 1 | Enable level; low stops the block and clears the fault |
| tgtProgrammed | input | 1 | 1 selects `targetStep` as target, 0 selects full scale |
| targetStep | input | CODE_W | Programmed target code |
| swCycle | input | 1 | One-clock pulse per switching cycle |
| ovFlag | input | 1 | Output over-voltage comparator flag |
| fbLowFlag | input | 1 | Feedback below half of reference flag |
| uvFlag | input | 1 | Input undervoltage flag |
| otFlag | input | 1 | Over-temperature flag |
| refStep | output | CODE_W | Reference code presented to the loop |
| halfLimit | output | 1 | Reduced switch current-limit request |
| switchEn | output | 1 | Permission for the power switch to run |
| openLoadFault | output | 1 | Latched open-load shutdown indicator |

## Verification
The bench aims at the exact edge where the ramp advances and the half-limit window closes; an off-by-one timer would show a code or the flag one clock early or late. It lowers and then raises the programmed target mid-run, which a design that loaded the target directly would reveal as a jump of many codes. Open-load detection is exercised with seven good pulses, a broken pulse and seven more, which must not trip; a design that did not restart its count would shut down there. The latched fault is then held with the flags cleared to catch a design that released it by itself, and gated-off flags are pulsed to show that only the switch enable responds.

// File: rtl/ssr_pkg.sv
package ssr_pkg;

  typedef enum logic [1:0] {
    ST_OFF   = 2'd0,
    ST_RUN   = 2'd1,
    ST_FAULT = 2'd2
  } seqState_t;

  // Strobes from the sequencing control to the reference datapath.
  typedef struct packed {
    logic clearRef;  // drive the reference code to zero on this edge
    logic stepTick;  // advance the reference one code toward the target
  } rampStrobe_t;

endpackage

// File: rtl/ssr_ctrl.sv
module ssr_ctrl
  import ssr_pkg::*;
#(
  parameter int STEP_CYCLES     = 8,
  parameter int HALF_LIM_CYCLES = 188,
  parameter int OL_CYCLES       = 8
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        en,
  input  logic        swCycle,
  input  logic        ovFlag,
  input  logic        fbLowFlag,
  input  logic        uvFlag,
  input  logic        otFlag,
  output rampStrobe_t strb,
  output logic        halfLimit,
  output logic        switchEn,
  output logic        openLoadFault
);

  localparam int STEP_W = (STEP_CYCLES > 1) ? $clog2(STEP_CYCLES) : 1;
  localparam int HALF_W = $clog2(HALF_LIM_CYCLES + 2);
  localparam int OL_W   = (OL_CYCLES > 1) ? $clog2(OL_CYCLES) : 1;

  localparam logic [STEP_W-1:0] STEP_LAST = STEP_W'(STEP_CYCLES - 1);
  localparam logic [HALF_W-1:0] HALF_END  = HALF_W'(HALF_LIM_CYCLES);
  localparam logic [OL_W-1:0]   OL_LAST   = OL_W'(OL_CYCLES - 1);

  seqState_t         state;
  seqState_t         nextState;
  logic [STEP_W-1:0] stepTmr;
  logic [HALF_W-1:0] startTmr;
  logic [OL_W-1:0]   olCnt;
  logic              olHit;
  logic              olTrip;
  logic              stayRun;

  assign olHit   = swCycle && ovFlag && fbLowFlag;
  assign olTrip  = (state == ST_RUN) && olHit && (olCnt == OL_LAST);

  always_comb begin
    if (!en)                                nextState = ST_OFF;
    else if ((state == ST_FAULT) || olTrip) nextState = ST_FAULT;
    else                                    nextState = ST_RUN;
  end

  assign stayRun = (state == ST_RUN) && (nextState == ST_RUN);

  always_comb begin
    strb.clearRef = (nextState != ST_RUN);
    strb.stepTick = stayRun && (stepTmr == STEP_LAST);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state    <= ST_OFF;
      stepTmr  <= '0;
      startTmr <= '0;
      olCnt    <= '0;
      switchEn <= 1'b0;
    end else begin
      state    <= nextState;
      switchEn <= (nextState == ST_RUN) && !uvFlag && !otFlag;
      if (!stayRun) begin
        stepTmr  <= '0;
        startTmr <= '0;
        olCnt    <= '0;
      end else begin
        stepTmr <= (stepTmr == STEP_LAST) ? '0 : stepTmr + 1'b1;
        if (startTmr < HALF_END) startTmr <= startTmr + 1'b1;
        if (swCycle) olCnt <= olHit ? olCnt + 1'b1 : '0;
      end
    end
  end

  assign halfLimit     = (state == ST_RUN) && (startTmr < HALF_END);
  assign openLoadFault = (state == ST_FAULT);

  // A latched open-load fault never coexists with an enabled switch (R6)
  assert_fault_no_switch_R6: assert property (@(posedge clk) disable iff (!rst_n)
    openLoadFault |-> !switchEn);

  // Fault holds while enable stays high (R8)
  assert_fault_sticky_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (openLoadFault && en) |=> openLoadFault);

  // Disabled block is quiet one clock later (R1)
  assert_disabled_quiet_R1: assert property (@(posedge clk) disable iff (!rst_n)
    !en |=> (!switchEn && !openLoadFault && !halfLimit));

  // Undervoltage gates the switch (R9)
  assert_uv_gates_R9: assert property (@(posedge clk) disable iff (!rst_n)
    uvFlag |=> !switchEn);

  // Over-temperature gates the switch (R10)
  assert_ot_gates_R10: assert property (@(posedge clk) disable iff (!rst_n)
    otFlag |=> !switchEn);

  // Half-limit never re-asserts inside a run once dropped (R5)
  assert_half_once_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (!halfLimit && (state == ST_RUN) && en && !olTrip) |=> !halfLimit);

endmodule

// File: rtl/ssr_datapath.sv
module ssr_datapath
  import ssr_pkg::*;
#(
  parameter int CODE_W = 5
) (
  input  logic              clk,
  input  logic              rst_n,
  input  rampStrobe_t       strb,
  input  logic              tgtProgrammed,
  input  logic [CODE_W-1:0] targetStep,
  output logic [CODE_W-1:0] refStep
);

  localparam logic [CODE_W-1:0] FULL_SCALE = '1;

  logic [CODE_W-1:0] target;
  logic              belowTgt;
  logic              aboveTgt;

  assign target   = tgtProgrammed ? targetStep : FULL_SCALE;
  assign belowTgt = (refStep < target);
  assign aboveTgt = (refStep > target);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      refStep <= '0;
    end else if (strb.clearRef) begin
      refStep <= '0;
    end else if (strb.stepTick) begin
      if (belowTgt)      refStep <= refStep + 1'b1;
      else if (aboveTgt) refStep <= refStep - 1'b1;
    end
  end

  // Reference moves by at most one code per edge while not cleared (R4)
  assert_ref_single_step_R4: assert property (@(posedge clk) disable iff (!rst_n)
    !strb.clearRef |=> ((refStep == $past(refStep)) ||
                        (refStep == CODE_W'($past(refStep) + 1'b1)) ||
                        (refStep == CODE_W'($past(refStep) - 1'b1))));

  // A clear strobe leaves the reference at zero (R8)
  assert_clear_zero_R8: assert property (@(posedge clk) disable iff (!rst_n)
    strb.clearRef |=> (refStep == '0));

endmodule

// File: rtl/softstart_ref_seq.sv
module softstart_ref_seq
  import ssr_pkg::*;
#(
  parameter int CODE_W          = 5,
  parameter int STEP_CYCLES     = 8,
  parameter int HALF_LIM_CYCLES = 188,
  parameter int OL_CYCLES       = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              en,
  input  logic              tgtProgrammed,
  input  logic [CODE_W-1:0] targetStep,
  input  logic              swCycle,
  input  logic              ovFlag,
  input  logic              fbLowFlag,
  input  logic              uvFlag,
  input  logic              otFlag,
  output logic [CODE_W-1:0] refStep,
  output logic              halfLimit,
  output logic              switchEn,
  output logic              openLoadFault
);

  rampStrobe_t strb;

  ssr_ctrl #(
    .STEP_CYCLES    (STEP_CYCLES),
    .HALF_LIM_CYCLES(HALF_LIM_CYCLES),
    .OL_CYCLES      (OL_CYCLES)
  ) u_ctrl (
    .clk          (clk),
    .rst_n        (rst_n),
    .en           (en),
    .swCycle      (swCycle),
    .ovFlag       (ovFlag),
    .fbLowFlag    (fbLowFlag),
    .uvFlag       (uvFlag),
    .otFlag       (otFlag),
    .strb         (strb),
    .halfLimit    (halfLimit),
    .switchEn     (switchEn),
    .openLoadFault(openLoadFault)
  );

  ssr_datapath #(
    .CODE_W(CODE_W)
  ) u_dp (
    .clk          (clk),
    .rst_n        (rst_n),
    .strb         (strb),
    .tgtProgrammed(tgtProgrammed),
    .targetStep   (targetStep),
    .refStep      (refStep)
  );

endmodule

// File: tb/softstart_ref_seq_tb.sv
module softstart_ref_seq_tb;

  localparam int STEP = 8;
  localparam int HALF = 188;
  localparam int OL   = 8;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       en = 1'b0;
  logic       tgtProgrammed = 1'b0;
  logic [4:0] targetStep = '0;
  logic       swCycle = 1'b0;
  logic       ovFlag = 1'b0;
  logic       fbLowFlag = 1'b0;
  logic       uvFlag = 1'b0;
  logic       otFlag = 1'b0;
  logic [4:0] refStep;
  logic       halfLimit;
  logic       switchEn;
  logic       openLoadFault;

  int checks = 0;
  int errors = 0;
  bit started = 0;
  bit done = 0;

  // behavioural model state: 0 off, 1 running, 2 faulted
  int mState = 0, mStep = 0, mStart = 0, mOl = 0, mRef = 0, mSw = 0;
  int nx, tgt;
  bit hit, trip;

  always #2 clk = ~clk;

  softstart_ref_seq u_dut (
    .clk(clk), .rst_n(rst_n), .en(en), .tgtProgrammed(tgtProgrammed),
    .targetStep(targetStep), .swCycle(swCycle), .ovFlag(ovFlag),
    .fbLowFlag(fbLowFlag), .uvFlag(uvFlag), .otFlag(otFlag),
    .refStep(refStep), .halfLimit(halfLimit), .switchEn(switchEn),
    .openLoadFault(openLoadFault)
  );

  task automatic chk(string tag, int got, int exp);
    checks++;
    if (got != exp) begin
      errors++;
      $display("FAIL %s got %0d expected %0d at %0t", tag, got, exp, $time);
    end
  endtask

  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      mState = 0; mStep = 0; mStart = 0; mOl = 0; mRef = 0; mSw = 0;
    end else begin
      started = 1;
      hit  = swCycle && ovFlag && fbLowFlag;
      trip = (mState == 1) && hit && (mOl == OL - 1);
      if (!en) nx = 0;
      else if (mState == 2 || trip) nx = 2;
      else nx = 1;
      tgt = tgtProgrammed ? int'(targetStep) : 31;
      if (nx != 1) mRef = 0;
      else if (mState == 1 && mStep == STEP - 1) begin
        if (mRef < tgt) mRef++;
        else if (mRef > tgt) mRef--;
      end
      if (mState == 1 && nx == 1) begin
        mStep = (mStep + 1) % STEP;
        if (mStart < HALF) mStart++;
        if (swCycle) mOl = hit ? mOl + 1 : 0;
      end else begin
        mStep = 0; mStart = 0; mOl = 0;
      end
      mSw = (nx == 1 && !uvFlag && !otFlag) ? 1 : 0;
      mState = nx;
    end
  end

  // per-cycle comparison against the model
  always @(negedge clk) begin
    if (started && !done) begin
      chk("R2/R4 refStep model", int'(refStep), mRef);
      chk("R5 halfLimit model", int'(halfLimit), (mState == 1 && mStart < HALF) ? 1 : 0);
      chk("R11 switchEn model", int'(switchEn), mSw);
      chk("R6 openLoadFault model", int'(openLoadFault), (mState == 2) ? 1 : 0);
    end
  end

  task automatic cyc(int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic olPulse(bit ovv, bit fbv);
    ovFlag = ovv; fbLowFlag = fbv; swCycle = 1'b1;
    @(negedge clk);
    swCycle = 1'b0;
    cyc(2);
  endtask

  initial begin
    #(200000 * 4);
    if (!done) begin
      done = 1;
      errors++;
      $display("FAIL watchdog expired");
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    cyc(3);
    chk("R1 reset refStep", int'(refStep), 0);
    chk("R1 reset switchEn", int'(switchEn), 0);
    chk("R1 reset halfLimit", int'(halfLimit), 0);
    rst_n = 1'b1;
    cyc(5);
    chk("R1 disabled switchEn", int'(switchEn), 0);
    chk("R1 disabled refStep", int'(refStep), 0);

    en = 1'b1;
    cyc(1);
    chk("R11 switch on at start", int'(switchEn), 1);
    chk("R5 half limit at start", int'(halfLimit), 1);
    chk("R2 ramp starts at zero", int'(refStep), 0);
    cyc(8);
    chk("R2 first step after one period", int'(refStep), 1);
    cyc(179);
    chk("R5 half limit last cycle", int'(halfLimit), 1);
    cyc(1);
    chk("R5 half limit ended", int'(halfLimit), 0);
    cyc(71);
    chk("R3 default full scale", int'(refStep), 31);

    uvFlag = 1'b1;
    cyc(1);
    chk("R9 uv gates switch", int'(switchEn), 0);
    chk("R9 ref kept under uv", int'(refStep), 31);
    cyc(2);
    uvFlag = 1'b0;
    cyc(1);
    chk("R9 switch resumes", int'(switchEn), 1);

    otFlag = 1'b1;
    cyc(1);
    chk("R10 ot gates switch", int'(switchEn), 0);
    cyc(3);
    otFlag = 1'b0;
    cyc(1);
    chk("R10 switch resumes", int'(switchEn), 1);

    tgtProgrammed = 1'b1;
    targetStep = 5'd10;
    cyc(200);
    chk("R4 ramp down reached", int'(refStep), 10);
    targetStep = 5'd14;
    cyc(40);
    chk("R4 ramp up reached", int'(refStep), 14);

    for (int i = 0; i < 7; i++) olPulse(1'b1, 1'b1);
    olPulse(1'b1, 1'b0);
    for (int i = 0; i < 7; i++) olPulse(1'b1, 1'b1);
    chk("R7 broken run no trip", int'(openLoadFault), 0);
    chk("R7 switch still on", int'(switchEn), 1);
    olPulse(1'b1, 1'b1);
    chk("R6 open load latched", int'(openLoadFault), 1);
    chk("R6 switch off", int'(switchEn), 0);
    chk("R6 ref cleared", int'(refStep), 0);

    ovFlag = 1'b0; fbLowFlag = 1'b0;
    cyc(20);
    chk("R8 fault sticky", int'(openLoadFault), 1);
    chk("R8 switch stays off", int'(switchEn), 0);
    chk("R8 half limit off", int'(halfLimit), 0);

    en = 1'b0;
    targetStep = 5'd3;
    cyc(1);
    chk("R8 fault cleared by disable", int'(openLoadFault), 0);
    chk("R1 ref zero disabled", int'(refStep), 0);
    en = 1'b1;
    cyc(1);
    chk("R8 fresh start switch", int'(switchEn), 1);
    chk("R8 fresh start half limit", int'(halfLimit), 1);
    cyc(40);
    chk("R3 programmed target", int'(refStep), 3);

    if (!done) begin
      done = 1;
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

endmodule